// File: doc/BRIEF.md
# Receive Lane Termination Controller

This block sets the switchable differential termination of one high-speed receive lane. It holds a 7-bit termination setting. The setting must be a thermometer code: a run of ones that starts at bit 0. Each bit of the setting enables one resistor leg in the analog termination network. A leg that is enabled lowers the effective impedance. The all-zero code gives the highest impedance, about 113 ohms. Each extra leg steps it down towards about 87 ohms when all seven legs are on.

The legs reach the analog side only while the lane reports high-speed receive mode. In low-power signalling every leg is open. The leg outputs come from a register, so they change without glitches. A write of a setting that is not a thermometer code leaves the setting as it was and raises a sticky error flag.

A test controller can start a sweep. The sweep visits the eight legal settings from 0 to 127 in rising order. Each new setting is the previous one shifted left one place with a one inserted at bit 0. After every change of the setting, a programmable settle counter runs, and at its end a one-cycle done strobe marks that the setting has settled. The counter advances only while power-good is high. A sweep can start only while power-good is high.

Top module: `rx_term_ctrl`

## Requirements
- R1: After reset, the setting is 0, all leg enables are 0, the error flag is 0, the done strobe is 0 and the sweep is idle.
- R2: When no sweep is running, a write of a legal code (a value of the form 2^k-1 for k from 0 to 7: 0, 1, 3, 7, 15, 31, 63, 127) loads that code into the setting at the next clock edge.
- R3: When no sweep is running, a write of a code that is not of the form 2^k-1 leaves the setting unchanged and sets the error flag. The error flag then stays set until reset.
- R4: At each clock edge the leg enables take the setting's current value when high-speed mode is high, and all zeros when it is low. Bit i of the leg enables drives leg i.
- R5: Suppose the setting is loaded at clock edge E and power-good stays high. Then the done strobe is high for exactly one cycle, starting at edge E+N+1, where N is the settle count. N = 0 is allowed.
- R6: While power-good is low, the settle counter holds its value and the done strobe stays low. A sweep start request made while power-good is low is ignored.
- R7: A sweep start request, when accepted, loads setting 0 and sets the busy output. When a done strobe occurs during a sweep and the setting is below 127, the next edge loads the setting shifted left by one with a one in bit 0. When the done strobe for 127 occurs, the next edge clears busy. The sweep therefore gives eight done strobes with the settings 0, 1, 3, 7, 15, 31, 63, 127 in that order.
- R8: While a sweep is running, writes and new sweep start requests are ignored: they change neither the setting nor the error flag.
- R9: The setting is always a legal thermometer code.
- R10: When a sweep start request is accepted in the same cycle as a write, the sweep takes priority and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hs_mode | input | 1 | Lane is in high-speed receive mode |
| pwr_good | input | 1 | Power-good; gates the settle counter and the sweep start |
| cfg_wr | input | 1 | One-cycle write strobe for the setting |
| cfg_code | input | 7 | Setting value to write |
| settle_cycles | input | CNT_W (16) | Settle count N used after each change of the setting |
| sweep_start | input | 1 | Request to start a sweep of the legal settings |
| term_leg_en | output | 7 | Registered resistor-leg enables to the analog termination |
| cur_code | output | 7 | Current setting |
| code_err | output | 1 | Sticky flag: an illegal code was written |
| cfg_done | output | 1 | One-cycle strobe: the current setting has settled |
| sweep_busy | output | 1 | A sweep is in progress |

## Verification
The assertions take settle_cycles to be steady while a settle count is running. The stimulus changes it only when the block is idle with nothing pending. The leg-gating property takes it that hs_mode is sampled at the clock edge. The bench changes hs_mode, pwr_good, cfg_wr and sweep_start only on the falling edge, so every rising edge sees settled values. Writes, illegal codes and start requests are deliberately placed while a sweep runs, while power-good is low, and in the same cycle as each other.

// File: rtl/rx_term_pkg.sv
package rx_term_pkg;
  localparam int TERM_W    = 7;
  localparam int NUM_CODES = TERM_W + 1;
  typedef logic [TERM_W-1:0] term_code_t;
  localparam term_code_t CODE_ZERO = '0;
  localparam term_code_t CODE_FULL = '1;

  // a thermometer code plus one is a power of two, so the AND is zero
  function automatic logic is_thermo(term_code_t c);
    term_code_t inc;
    inc = c + term_code_t'(1);
    return ((c & inc) == CODE_ZERO);
  endfunction

  // one more leg: shift up and fill the bottom bit
  function automatic term_code_t next_code(term_code_t c);
    return {c[TERM_W-2:0], 1'b1};
  endfunction
endpackage

// File: rtl/rx_term_settle_timer.sv
module rx_term_settle_timer
  import rx_term_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart_i,
  input  logic             pwr_good_i,
  input  logic [CNT_W-1:0] settle_i,
  output logic             done_o
);
  logic             pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  // named events for the assertions
  logic tick;
  logic expire;
  assign tick   = pend_q & pwr_good_i & ~restart_i;
  assign expire = tick & (cnt_q >= settle_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= expire;
      if (restart_i) begin
        pend_q <= 1'b1;
        cnt_q  <= '0;
      end else if (tick) begin
        if (expire) pend_q <= 1'b0;
        else        cnt_q  <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign done_o = done_q;

  p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good_i |=> !done_q);
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_hold_cnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwr_good_i && !restart_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rx_term_code_reg.sv
module rx_term_code_reg
  import rx_term_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_i,
  input  term_code_t wdata_i,
  input  logic       busy_i,
  input  logic       seq_load_i,
  input  term_code_t seq_code_i,
  output term_code_t code_o,
  output logic       err_o,
  output logic       load_o
);
  term_code_t code_q;
  logic       err_q;

  logic wr_take;
  logic wr_legal;
  logic bad_wr;
  assign wr_take  = wr_i & ~busy_i & ~seq_load_i;
  assign wr_legal = is_thermo(wdata_i);
  assign bad_wr   = wr_take & ~wr_legal;
  assign load_o   = seq_load_i | (wr_take & wr_legal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CODE_ZERO;
      err_q  <= 1'b0;
    end else begin
      if (seq_load_i)                 code_q <= seq_code_i;
      else if (wr_take && wr_legal)   code_q <= wdata_i;
      if (bad_wr) err_q <= 1'b1;
    end
  end

  assign code_o = code_q;
  assign err_o  = err_q;

  p_code_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    is_thermo(code_q));
  p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
  p_bad_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> $stable(code_q));
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && !seq_load_i) |=> $stable(code_q) && ($stable(err_q)));
endmodule

// File: rtl/rx_term_sweep_seq.sv
module rx_term_sweep_seq
  import rx_term_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       pwr_good_i,
  input  logic       done_i,
  input  term_code_t code_i,
  output logic       busy_o,
  output logic       load_o,
  output term_code_t code_o
);
  logic busy_q;

  logic start_acc;
  logic step_adv;
  logic step_last;
  assign start_acc = start_i & ~busy_q & pwr_good_i;
  assign step_adv  = busy_q & done_i & (code_i != CODE_FULL);
  assign step_last = busy_q & done_i & (code_i == CODE_FULL);

  assign load_o = start_acc | step_adv;
  assign code_o = start_acc ? CODE_ZERO : next_code(code_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         busy_q <= 1'b0;
    else if (start_acc) busy_q <= 1'b1;
    else if (step_last) busy_q <= 1'b0;
  end

  assign busy_o = busy_q;

  p_start_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> (code_i == CODE_ZERO) && busy_q);
  p_step_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step_adv |=> code_i == next_code($past(code_i)));
  p_end_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    step_last |=> !busy_q);
  p_no_start_lp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !pwr_good_i) |=> !busy_q);
endmodule

// File: rtl/rx_term_leg_drv.sv
module rx_term_leg_drv
  import rx_term_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hs_i,
  input  term_code_t code_i,
  output term_code_t leg_o
);
  term_code_t leg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    leg_q <= CODE_ZERO;
    else if (hs_i) leg_q <= code_i;
    else           leg_q <= CODE_ZERO;
  end

  assign leg_o = leg_q;

  p_leg_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (leg_q != CODE_ZERO) |-> $past(hs_i));
  p_leg_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    is_thermo(leg_q));
endmodule

// File: rtl/rx_term_ctrl.sv
module rx_term_ctrl
  import rx_term_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_mode,
  input  logic             pwr_good,
  input  logic             cfg_wr,
  input  logic [6:0]       cfg_code,
  input  logic [CNT_W-1:0] settle_cycles,
  input  logic             sweep_start,
  output logic [6:0]       term_leg_en,
  output logic [6:0]       cur_code,
  output logic             code_err,
  output logic             cfg_done,
  output logic             sweep_busy
);
  term_code_t code_w;
  term_code_t seq_code_w;
  term_code_t leg_w;
  logic       seq_load_w;
  logic       code_load_w;
  logic       busy_w;
  logic       done_w;
  logic       err_w;

  rx_term_sweep_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (sweep_start),
    .pwr_good_i (pwr_good),
    .done_i     (done_w),
    .code_i     (code_w),
    .busy_o     (busy_w),
    .load_o     (seq_load_w),
    .code_o     (seq_code_w)
  );

  rx_term_code_reg u_code (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (cfg_wr),
    .wdata_i    (cfg_code),
    .busy_i     (busy_w),
    .seq_load_i (seq_load_w),
    .seq_code_i (seq_code_w),
    .code_o     (code_w),
    .err_o      (err_w),
    .load_o     (code_load_w)
  );

  rx_term_settle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart_i  (code_load_w),
    .pwr_good_i (pwr_good),
    .settle_i   (settle_cycles),
    .done_o     (done_w)
  );

  rx_term_leg_drv u_leg (
    .clk    (clk),
    .rst_n  (rst_n),
    .hs_i   (hs_mode),
    .code_i (code_w),
    .leg_o  (leg_w)
  );

  assign term_leg_en = leg_w;
  assign cur_code    = code_w;
  assign code_err    = err_w;
  assign cfg_done    = done_w;
  assign sweep_busy  = busy_w;

  p_sweep_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_start && !busy_w && pwr_good) |=> (code_w == CODE_ZERO) && !$changed(err_w));
endmodule

// File: tb/tb_rx_term_ctrl.sv
`timescale 1ns/1ps
module tb_rx_term_ctrl;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hs_mode = 1'b0;
  logic          pwr_good = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [6:0]    cfg_code = '0;
  logic [CW-1:0] settle = CW'(3);
  logic          sweep_start = 1'b0;
  logic [6:0]    term_leg_en;
  logic [6:0]    cur_code;
  logic          code_err;
  logic          cfg_done;
  logic          sweep_busy;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int done_log[$];

  always #2.5 clk = ~clk;

  rx_term_ctrl #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .hs_mode(hs_mode), .pwr_good(pwr_good),
    .cfg_wr(cfg_wr), .cfg_code(cfg_code), .settle_cycles(settle),
    .sweep_start(sweep_start), .term_leg_en(term_leg_en), .cur_code(cur_code),
    .code_err(code_err), .cfg_done(cfg_done), .sweep_busy(sweep_busy)
  );

  function automatic bit legal(int v);
    for (int k = 0; k <= 7; k++) if (v == (1 << k) - 1) return 1;
    return 0;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_code, m_err, m_legs, m_done, m_busy, m_pend, m_cnt;
  always @(posedge clk or negedge rst_n) begin
    int c, e, b, p, n, d, ld;
    if (!rst_n) begin
      m_code <= 0; m_err <= 0; m_legs <= 0; m_done <= 0;
      m_busy <= 0; m_pend <= 0; m_cnt <= 0;
    end else begin
      c = m_code; e = m_err; b = m_busy; p = m_pend; n = m_cnt; d = 0; ld = 0;
      if (sweep_start && m_busy == 0 && pwr_good) begin
        c = 0; b = 1; ld = 1;
      end else if (m_busy != 0 && m_done != 0) begin
        if (m_code == 127) b = 0;
        else begin c = m_code * 2 + 1; ld = 1; end
      end else if (cfg_wr && m_busy == 0) begin
        if (legal(int'(cfg_code))) begin c = int'(cfg_code); ld = 1; end
        else e = 1;
      end
      if (ld != 0) begin p = 1; n = 0; end
      else if (m_pend != 0 && pwr_good) begin
        if (m_cnt >= int'(settle)) begin d = 1; p = 0; end
        else n = m_cnt + 1;
      end
      m_legs <= hs_mode ? m_code : 0;
      m_code <= c; m_err <= e; m_busy <= b; m_pend <= p; m_cnt <= n; m_done <= d;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(int'(cur_code) == m_code, "R2 setting", int'(cur_code), m_code);
      chk(int'(code_err) == m_err, "R3 error flag", int'(code_err), m_err);
      chk(int'(term_leg_en) == m_legs, "R4 leg enables", int'(term_leg_en), m_legs);
      chk(int'(cfg_done) == m_done, "R5 done strobe", int'(cfg_done), m_done);
      chk(int'(sweep_busy) == m_busy, "R7 busy", int'(sweep_busy), m_busy);
      chk(legal(int'(cur_code)), "R9 legal setting", int'(cur_code), 1);
      if (cfg_done) done_log.push_back(int'(cur_code));
    end
  end

  task automatic write_code(int v);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_code = 7'(v);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_done(output int cycles);
    cycles = 0;
    for (int i = 1; i <= 200; i++) begin
      @(negedge clk);
      if (cfg_done) begin cycles = i; break; end
    end
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!sweep_busy) break;
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int cyc;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cur_code == 0 && term_leg_en == 0, "R1 reset code/legs", int'(cur_code), 0);
    chk(!code_err && !cfg_done && !sweep_busy, "R1 reset flags",
        int'({code_err, cfg_done, sweep_busy}), 0);

    hs_mode = 1'b1; pwr_good = 1'b1;
    // R2 legal write
    write_code(7);
    chk(cur_code == 7, "R2 legal write", int'(cur_code), 7);
    @(negedge clk);
    chk(term_leg_en == 7, "R4 legs follow in hs", int'(term_leg_en), 7);
    // R5 settle timing: load edge already passed, done on 4th edge for N=3
    write_code(15);
    wait_done(cyc);
    chk(cyc == 4, "R5 settle N=3", cyc, 4);
    @(negedge clk);
    chk(!cfg_done, "R5 one-cycle strobe", int'(cfg_done), 0);

    // R4 low-power disconnect
    hs_mode = 1'b0;
    repeat (2) @(negedge clk);
    chk(term_leg_en == 0, "R4 legs off in lp", int'(term_leg_en), 0);
    hs_mode = 1'b1;

    // R6 power-good gating
    pwr_good = 1'b0;
    write_code(31);
    seen = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (cfg_done) seen = 1; end
    chk(!seen, "R6 frozen without power-good", int'(seen), 0);
    sweep_start = 1'b1; @(negedge clk); sweep_start = 1'b0;
    @(negedge clk);
    chk(!sweep_busy, "R6 start ignored", int'(sweep_busy), 0);
    pwr_good = 1'b1;
    wait_done(cyc);
    chk(cyc == 4, "R6 resumes after power-good", cyc, 4);
    repeat (2) @(negedge clk);

    // R7 sweep, R8 writes ignored during it
    settle = CW'(2);
    done_log.delete();
    sweep_start = 1'b1; @(negedge clk); sweep_start = 1'b0;
    chk(sweep_busy && cur_code == 0, "R7 sweep starts at 0", int'(cur_code), 0);
    repeat (5) @(negedge clk);
    write_code(5);
    chk(!code_err, "R8 illegal write ignored in sweep", int'(code_err), 0);
    write_code(127);
    chk(cur_code != 127, "R8 legal write ignored in sweep", int'(cur_code), -1);
    wait_idle();
    chk(done_log.size() == 8, "R7 eight steps", done_log.size(), 8);
    for (int k = 0; k < 8 && k < done_log.size(); k++)
      chk(done_log[k] == (1 << k) - 1, "R7 step order", done_log[k], (1 << k) - 1);

    // R3 illegal write
    write_code(63);
    write_code(5);
    chk(code_err && cur_code == 63, "R3 illegal write", int'(cur_code), 63);
    write_code(3);
    chk(code_err, "R3 sticky", int'(code_err), 1);
    repeat (6) @(negedge clk);

    // R10 sweep beats write
    @(negedge clk);
    sweep_start = 1'b1; cfg_wr = 1'b1; cfg_code = 7'd127;
    @(negedge clk);
    sweep_start = 1'b0; cfg_wr = 1'b0;
    chk(cur_code == 0 && sweep_busy, "R10 sweep priority", int'(cur_code), 0);
    wait_idle();

    // R5 with N=0
    settle = CW'(0);
    write_code(1);
    wait_done(cyc);
    chk(cyc == 1, "R5 settle N=0", cyc, 1);
    repeat (4) @(negedge clk);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule